// File: doc/BRIEF.md
# Shared Mailbox Address Generator

This block forms the address and strobes for a shared mailbox RAM. An external controller can hold the memory instead of the supervisor, and while it does, the block builds each RAM address from four fields. The highest field is the slot number that the access sequencer currently serves. Below it are the mailbox-select input, then the level of the external write-data-enable line, then a small word counter. The word counter steps once each time the external read strobe returns high, so a controller can walk its mailbox words by pulsing read. The counter clears at the start of every slot and wraps after its last word.

The grant input picks the owner of the RAM. With grant low, the supervisor's address and strobes pass straight through, and every external strobe is kept away from the memory. With grant high, the generated address and the external strobes drive the RAM. The write-data-enable level also sets the direction of the bidirectional data transceiver. The strobes are assumed to be synchronous to the block clock.

Top module: `mbx_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, with grant high, the word field of mem_addr is 0.
- R2: While grant is high, the word counter increases by one at the first clock edge that sees ext_rd_n high after it was sampled low.
- R3: The word counter wraps from its largest value (7 with WORD_W=3) to 0 on the next step.
- R4: A slot_start pulse clears the word counter to 0, and it takes precedence over a step seen at the same edge.
- R5: While grant is high, mem_addr is {slot, mbox_sel, ext_wr_en, word}. Bit 3 set to 1 selects the write region, and bit 4 set to 1 selects mailbox #1, with WORD_W=3.
- R6: xcvr_dir equals ext_wr_en while grant is high, where 1 means drive toward the RAM. It is 0 while grant is low.
- R7: While grant is low, mem_addr, mem_rd_n and mem_wr_n follow sup_addr, sup_rd_n and sup_wr_n, and the external strobes have no effect on them.
- R8: While grant is low, the word counter is held at 0. Once grant rises, the word field is 0 until the first step.
- R9: A read strobe that stays low, or stays high, across several clocks does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant | input | 1 | 1 = external controller owns the RAM |
| slot_start | input | 1 | One-cycle pulse marking the start of a slot |
| slot | input | SLOT_W | Current slot number from the access sequencer |
| mbox_sel | input | 1 | 1 = mailbox #1, 0 = the other mailbox |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_wr_en | input | 1 | Write-data-enable level: region bit and transceiver direction |
| sup_addr | input | AW | Supervisor address |
| sup_rd_n | input | 1 | Supervisor read strobe, active low |
| sup_wr_n | input | 1 | Supervisor write strobe, active low |
| mem_addr | output | AW | RAM address |
| mem_rd_n | output | 1 | RAM read strobe, active low |
| mem_wr_n | output | 1 | RAM write strobe, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward RAM |

## Verification
The bench builds the block with WORD_W=3 and SLOT_W=2. At these sizes, eight read pulses carry the counter through its full range and into the wrap. The 2-bit slot field is small enough that the bench can drive both of its extreme values and check them at the top of the address. It also places every single-bit field next to a neighbour that has the opposite value, which exposes any swapped or shifted field.

// File: rtl/mbx_pkg.sv
// Package: shared definitions for the mailbox address generator.
// Assumes the address is made of slot, mailbox select, direction and word fields.
package mbx_pkg;
    // Number of single-bit control fields between the slot and word fields
    localparam int MBX_CTRL_BITS = 2;

    // Transceiver direction encoding
    typedef enum logic {
        XDIR_TO_HOST = 1'b0,
        XDIR_TO_RAM  = 1'b1
    } xdir_e;
endpackage

// File: rtl/mbx_strobe_edge.sv
// Module: detects the return-high edge of an active-low strobe.
// Assumes the strobe is synchronous to clk; 'rise' is combinational and valid
// at the clock edge that first samples the strobe high after a low sample.
module mbx_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);
    logic prev_q;

    // Remember the previous sampled level; idle level is high
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= strobe_n;
    end

    // Low-to-high transition seen at this edge
    always_comb rise = strobe_n & ~prev_q;
endmodule

// File: rtl/mbx_word_ctr.sv
// Module: mailbox word counter that supplies the low address bits.
// Assumes 'en' is the grant level; clear has precedence over a step.
module mbx_word_ctr #(
    parameter int WORD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic              step,
    output logic [WORD_W-1:0] word
);
    // Count steps, clearing on slot start or while not granted
    always_ff @(posedge clk) begin
        if (!rst_n)          word <= '0;
        else if (!en || clr) word <= '0;
        else if (step)       word <= word + 1'b1;
    end

    // R2: a step while granted moves the counter on by one, wrapping (R3)
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && step) |=> (word == WORD_W'($past(word) + 1'b1)));

    // R4: a slot start leaves the counter at zero
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (word == '0));

    // R9: no step means no change while granted
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !step) |=> $stable(word));

    // R8: counter is zero after an edge without grant
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (word == '0));
endmodule

// File: rtl/mbx_addr_mux.sv
// Module: composes the generated address and selects between the supervisor
// path and the external path. Purely combinational.
// Assumes grant = 1 gives the external controller the RAM.
module mbx_addr_mux
    import mbx_pkg::*;
#(
    parameter int WORD_W = 3,
    parameter int SLOT_W = 3,
    localparam int AW = SLOT_W + MBX_CTRL_BITS + WORD_W
) (
    input  logic              grant,
    input  logic [SLOT_W-1:0] slot,
    input  logic              mbox_sel,
    input  logic              ext_wr_en,
    input  logic [WORD_W-1:0] word,
    input  logic              ext_rd_n,
    input  logic              ext_wr_n,
    input  logic [AW-1:0]     sup_addr,
    input  logic              sup_rd_n,
    input  logic              sup_wr_n,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              xcvr_dir
);
    logic [AW-1:0] gen_addr;

    // Build the external address: slot, mailbox, region, word (MSB to LSB)
    always_comb gen_addr = {slot, mbox_sel, ext_wr_en, word};

    // Route the owner's address and strobes to the RAM
    always_comb begin
        if (grant) begin
            mem_addr = gen_addr;
            mem_rd_n = ext_rd_n;
            mem_wr_n = ext_wr_n;
            xcvr_dir = ext_wr_en ? XDIR_TO_RAM : XDIR_TO_HOST;
        end else begin
            mem_addr = sup_addr;
            mem_rd_n = sup_rd_n;
            mem_wr_n = sup_wr_n;
            xcvr_dir = XDIR_TO_HOST;
        end
    end
endmodule

// File: rtl/mbx_addr_gen.sv
// Module: top of the shared mailbox address generator.
// Assumes all strobes and the grant are synchronous to clk; the external
// read strobe steps the word counter on its return high.
module mbx_addr_gen
    import mbx_pkg::*;
#(
    parameter int WORD_W = 3,
    parameter int SLOT_W = 3,
    localparam int AW = SLOT_W + MBX_CTRL_BITS + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              slot_start,
    input  logic [SLOT_W-1:0] slot,
    input  logic              mbox_sel,
    input  logic              ext_rd_n,
    input  logic              ext_wr_n,
    input  logic              ext_wr_en,
    input  logic [AW-1:0]     sup_addr,
    input  logic              sup_rd_n,
    input  logic              sup_wr_n,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              xcvr_dir
);
    logic              rd_rise;
    logic [WORD_W-1:0] word;

    mbx_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (ext_rd_n),
        .rise     (rd_rise)
    );

    mbx_word_ctr #(.WORD_W(WORD_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (grant),
        .clr   (slot_start),
        .step  (rd_rise),
        .word  (word)
    );

    mbx_addr_mux #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_mux (
        .grant     (grant),
        .slot      (slot),
        .mbox_sel  (mbox_sel),
        .ext_wr_en (ext_wr_en),
        .word      (word),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .sup_addr  (sup_addr),
        .sup_rd_n  (sup_rd_n),
        .sup_wr_n  (sup_wr_n),
        .mem_addr  (mem_addr),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .xcvr_dir  (xcvr_dir)
    );

    // R5: granted address carries the counter in its low field
    a_r5_word_field: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (mem_addr[WORD_W-1:0] == word));

    // R7: without grant the RAM read strobe is the supervisor's
    a_r7_isolate: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> (mem_rd_n == sup_rd_n && mem_wr_n == sup_wr_n));

    // R6: transceiver never points at the RAM without grant
    a_r6_dir_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> (xcvr_dir == 1'b0));
endmodule

// File: tb/sim_mbx_addr_gen.sv
module sim_mbx_addr_gen;
    localparam int WORD_W = 3;
    localparam int SLOT_W = 2;
    localparam int AW = SLOT_W + 2 + WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0, slot_start = 1'b0, mbox_sel = 1'b0;
    logic ext_rd_n = 1'b1, ext_wr_n = 1'b1, ext_wr_en = 1'b0;
    logic sup_rd_n = 1'b1, sup_wr_n = 1'b1;
    logic [SLOT_W-1:0] slot = '0;
    logic [AW-1:0] sup_addr = '0;
    logic [AW-1:0] mem_addr;
    logic mem_rd_n, mem_wr_n, xcvr_dir;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mbx_addr_gen #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .grant(grant), .slot_start(slot_start),
        .slot(slot), .mbox_sel(mbox_sel), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_wr_en(ext_wr_en), .sup_addr(sup_addr),
        .sup_rd_n(sup_rd_n), .sup_wr_n(sup_wr_n), .mem_addr(mem_addr),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .xcvr_dir(xcvr_dir)
    );

    function automatic logic [AW-1:0] exp_addr(logic [SLOT_W-1:0] s, logic m,
                                               logic w, int wd);
        return {s, m, w, WORD_W'(wd)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One full read pulse; the counter has stepped when this returns
    task automatic rd_pulse();
        @(negedge clk) ext_rd_n = 1'b0;
        @(negedge clk) ext_rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        grant = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 word after reset", 32'(mem_addr[WORD_W-1:0]), 0);
    endtask

    task automatic t_step_and_layout();
        slot = 2'b10; mbox_sel = 1'b1; ext_wr_en = 1'b0;
        @(negedge clk) slot_start = 1'b1;
        @(negedge clk) slot_start = 1'b0;
        rd_pulse();
        check("R2 one step", 32'(mem_addr), 32'(exp_addr(2'b10, 1'b1, 1'b0, 1)));
        rd_pulse();
        check("R2 two steps", 32'(mem_addr), 32'(exp_addr(2'b10, 1'b1, 1'b0, 2)));
        ext_wr_en = 1'b1; mbox_sel = 1'b0; slot = 2'b01;
        #1;
        check("R5 field layout", 32'(mem_addr), 32'(exp_addr(2'b01, 1'b0, 1'b1, 2)));
        check("R6 dir write", 32'(xcvr_dir), 1);
        ext_wr_en = 1'b0;
        #1;
        check("R6 dir read", 32'(xcvr_dir), 0);
        slot = 2'b11; mbox_sel = 1'b1; ext_wr_en = 1'b1;
        #1;
        check("R5 all ones fields", 32'(mem_addr), 32'(exp_addr(2'b11, 1'b1, 1'b1, 2)));
    endtask

    task automatic t_wrap();
        @(negedge clk) slot_start = 1'b1;
        @(negedge clk) slot_start = 1'b0;
        for (int i = 0; i < 7; i++) rd_pulse();
        check("R3 at top", 32'(mem_addr[WORD_W-1:0]), 7);
        rd_pulse();
        check("R3 wrapped", 32'(mem_addr[WORD_W-1:0]), 0);
    endtask

    task automatic t_hold_levels();
        rd_pulse();
        @(negedge clk) ext_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 held low", 32'(mem_addr[WORD_W-1:0]), 1);
        ext_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 held high after one rise", 32'(mem_addr[WORD_W-1:0]), 2);
    endtask

    task automatic t_clear_priority();
        @(negedge clk) ext_rd_n = 1'b0;
        @(negedge clk) begin ext_rd_n = 1'b1; slot_start = 1'b1; end
        @(negedge clk) slot_start = 1'b0;
        check("R4 clear beats step", 32'(mem_addr[WORD_W-1:0]), 0);
    endtask

    task automatic t_isolate();
        rd_pulse(); rd_pulse();
        @(negedge clk) begin
            grant = 1'b0; sup_addr = 7'h5A; sup_rd_n = 1'b0; sup_wr_n = 1'b1;
        end
        ext_rd_n = 1'b1; ext_wr_n = 1'b0; ext_wr_en = 1'b1;
        #1;
        check("R7 addr follows supervisor", 32'(mem_addr), 32'h5A);
        check("R7 rd follows supervisor", 32'(mem_rd_n), 0);
        check("R7 wr ignores external", 32'(mem_wr_n), 1);
        check("R6 dir without grant", 32'(xcvr_dir), 0);
        ext_wr_n = 1'b1;
        rd_pulse(); rd_pulse();
        check("R7 strobes ignored", 32'(mem_addr), 32'h5A);
        @(negedge clk) grant = 1'b1;
        #1;
        check("R8 zero after regrant", 32'(mem_addr[WORD_W-1:0]), 0);
    endtask

    initial begin
        t_reset();
        t_step_and_layout();
        t_wrap();
        t_hold_levels();
        t_clear_priority();
        t_isolate();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule